// File: doc/BRIEF.md
# Sleep and Clock-Gating Power Controller

This controller decides which clock domains of a small microcontroller run at any moment. Software sets a sleep-enable bit and picks a depth with a 2-bit mode code, then raises a sleep request. The controller walks through an entry phase, parks in the chosen depth and waits for a wake source that is valid for that depth. It then runs a fixed wake count with the brown-out detector already back on, and only after that lets the CPU clock run again. No reset is issued on wake; every domain keeps its contents.

Depths: Idle (code 00) stops only the CPU clock. Power Save (01) stops everything except the 32 kHz real-time-counter domain. Power Down (10) stops every domain, including the main oscillator and the real-time counter. Code 11 is reserved. Alongside the sleep depths, a per-peripheral power-reduction vector stops that peripheral's clock. It also shuts off its register strobes, so a blocked read returns zero and a blocked write reaches nothing.

The sequencer has four named states, reported on `state_o`: RUN (00), ENTER (01), SLEEP (10) and WAKE (11). Its transitions are:
- RUN→ENTER on an accepted request.
- ENTER→SLEEP when the entry count ends.
- ENTER→RUN (abort) on a qualifying wake.
- SLEEP→WAKE on a qualifying wake.
- WAKE→RUN when the wake count ends.

Top module: `pmu_sleep_ctrl`

## Requirements
- R1: While reset is held, `state_o` is RUN (00), the CPU, bus, oscillator, RTC and brown-out enables are high, and every bit of `per_clk_en` is high.
- R2: A sleep request is taken only in RUN, only with `sleep_en` high and only with a mode other than 11. Otherwise the state stays RUN.
- R3: After an accepted request the state is ENTER for ENTRY_CYC cycles, then SLEEP. During ENTER the CPU enable is low and the other four domain enables are high.
- R4: In SLEEP with mode 00 (Idle), the CPU enable is low and the bus, oscillator, RTC and brown-out enables stay high.
- R5: In SLEEP with mode 01 (Power Save), only the RTC enable is high. The CPU, bus, oscillator and brown-out enables are low.
- R6: In SLEEP with mode 10 (Power Down), all five domain enables are low.
- R7: The wake sources that count depend on the mode. In Idle, any of `irq_sync`, `irq_async`, `rtc_tick` and `ext_wake` counts. In Power Save, only `irq_async`, `rtc_tick` and `ext_wake` count. In Power Down, only `irq_async` and `ext_wake` count. Any other source leaves the state at SLEEP.
- R8: The state becomes WAKE at the clock edge that samples a qualifying wake. It returns to RUN exactly WAKE_CYC edges later, and the CPU enable stays low for the whole of WAKE.
- R9: The brown-out enable is high throughout WAKE, so it is back on before the CPU enable rises.
- R10: A qualifying wake sampled during ENTER returns the state to RUN at that edge, without passing through SLEEP.
- R11: The domain enables and `per_clk_en` change only at the falling edge of `clk`, half a cycle after the state change that causes them.
- R12: `per_clk_en[i]` is high exactly when the bus domain is enabled and `prr[i]` is 0.
- R13: A bus access selects peripheral `bus_idx`. With `prr[i]` at 1, `per_wr_en[i]` and `per_rd_en[i]` stay 0 and `bus_rdata` is 0. With `prr[i]` at 0, the strobe goes to that peripheral and `bus_rdata` carries bits `[i*DATA_W +: DATA_W]` of `per_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_en | input | 1 | Sleep permission bit |
| sleep_req | input | 1 | Sleep request pulse from the CPU |
| sleep_mode | input | 2 | Depth: 00 Idle, 01 Power Save, 10 Power Down, 11 reserved |
| irq_sync | input | 1 | Clocked peripheral interrupt |
| irq_async | input | 1 | Asynchronous-capable interrupt |
| rtc_tick | input | 1 | Real-time-counter tick |
| ext_wake | input | 1 | External wake pin |
| prr | input | N_PERIPH | Power-reduction bits, one per peripheral |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_idx | input | IDX_W | Selected peripheral |
| per_rdata | input | N_PERIPH*DATA_W | Packed read data from all peripherals |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | Peripheral bus clock enable |
| osc_en | output | 1 | Main oscillator enable |
| rtc_clk_en | output | 1 | 32 kHz domain enable |
| bod_en | output | 1 | Brown-out detector enable |
| per_clk_en | output | N_PERIPH | Per-peripheral clock enables |
| per_wr_en | output | N_PERIPH | Per-peripheral write strobes |
| per_rd_en | output | N_PERIPH | Per-peripheral read strobes |
| bus_rdata | output | DATA_W | Read data returned to the bus |
| state_o | output | 2 | Sequencer state: 00 RUN, 01 ENTER, 10 SLEEP, 11 WAKE |

## Verification
The bench uses the default parameters: N_PERIPH=4, DATA_W=8, ENTRY_CYC=2 and WAKE_CYC=6. With a two-cycle entry, a wake can land inside ENTER and abort it, and the whole six-cycle wake window can be traced edge by edge. Four peripherals allow an alternating power-reduction pattern, so blocked and open slots sit next to each other on the same read mux. Each of the three depths is entered and left, and the sources that must not wake a depth are offered to it while it sleeps.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_ENTER = 2'b01,
        ST_SLEEP = 2'b10,
        ST_WAKE  = 2'b11
    } pmu_state_e;

    typedef enum logic [1:0] {
        MD_IDLE = 2'b00,
        MD_SAVE = 2'b01,
        MD_DOWN = 2'b10,
        MD_RSVD = 2'b11
    } pmu_mode_e;

    typedef struct packed {
        logic cpu;
        logic bus;
        logic osc;
        logic rtc;
        logic bod;
    } dom_en_t;

    localparam dom_en_t DOM_ALL_ON = 5'b11111;

endpackage

// File: rtl/pmu_wake_qual.sv
module pmu_wake_qual
    import pmu_pkg::*;
(
    input  pmu_mode_e mode,
    input  logic      irq_sync,
    input  logic      irq_async,
    input  logic      rtc_tick,
    input  logic      ext_wake,
    output logic      wake
);

    // Deeper modes stop the clocks behind some sources, so fewer of them count.
    always_comb begin
        unique case (mode)
            MD_IDLE: wake = irq_sync | irq_async | rtc_tick | ext_wake;
            MD_SAVE: wake = irq_async | rtc_tick | ext_wake;
            MD_DOWN: wake = irq_async | ext_wake;
            MD_RSVD: wake = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmu_seq_fsm.sv
module pmu_seq_fsm
    import pmu_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int WAKE_CYC  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_en,
    input  logic       sleep_req,
    input  logic [1:0] mode_in,
    input  logic       wake,
    output pmu_state_e state,
    output pmu_mode_e  mode_q,
    output dom_en_t    dom_req
);

    localparam int MAX_CYC = (ENTRY_CYC > WAKE_CYC) ? ENTRY_CYC : WAKE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int WL_W    = $clog2(WAKE_CYC + 1) + 1;

    pmu_state_e       state_nx;
    pmu_mode_e        mode_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             accept;

    assign accept = sleep_req && sleep_en && (mode_in != 2'b11);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_RUN;
            mode_q <= MD_IDLE;
            cnt    <= '0;
        end else begin
            state  <= state_nx;
            mode_q <= mode_nx;
            cnt    <= cnt_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        mode_nx  = mode_q;
        cnt_nx   = cnt;
        unique case (state)
            ST_RUN: begin
                if (accept) begin
                    state_nx = ST_ENTER;
                    mode_nx  = pmu_mode_e'(mode_in);
                    cnt_nx   = CNT_W'(ENTRY_CYC - 1);
                end
            end
            ST_ENTER: begin
                if (wake) begin
                    state_nx = ST_RUN;
                end else if (cnt == '0) begin
                    state_nx = ST_SLEEP;
                end else begin
                    cnt_nx = cnt - CNT_W'(1);
                end
            end
            ST_SLEEP: begin
                if (wake) begin
                    state_nx = ST_WAKE;
                    cnt_nx   = CNT_W'(WAKE_CYC - 1);
                end
            end
            ST_WAKE: begin
                if (cnt == '0) begin
                    state_nx = ST_RUN;
                end else begin
                    cnt_nx = cnt - CNT_W'(1);
                end
            end
        endcase
    end

    // Domain enables wanted in each state
    always_comb begin
        dom_req = DOM_ALL_ON;
        unique case (state)
            ST_RUN:   dom_req = DOM_ALL_ON;
            ST_ENTER: dom_req.cpu = 1'b0;
            ST_WAKE:  dom_req.cpu = 1'b0;
            ST_SLEEP: begin
                unique case (mode_q)
                    MD_IDLE, MD_RSVD: dom_req.cpu = 1'b0;
                    MD_SAVE: dom_req = '{cpu: 1'b0, bus: 1'b0, osc: 1'b0, rtc: 1'b1, bod: 1'b0};
                    MD_DOWN: dom_req = '0;
                endcase
            end
        endcase
    end

    // Length of the current wake window, for the latency check
    logic [WL_W-1:0] wk_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                wk_len <= '0;
        else if (state == ST_WAKE) wk_len <= wk_len + WL_W'(1);
        else                       wk_len <= '0;
    end

    assert_req_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENTER && $past(state) == ST_RUN) |-> ($past(sleep_en) && $past(mode_in) != 2'b11));

    assert_wake_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) == ST_WAKE) |-> (wk_len == WL_W'(WAKE_CYC)));

    assert_sleep_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !wake) |=> (state == ST_SLEEP));

    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENTER && wake) |=> (state == ST_RUN));

endmodule

// File: rtl/pmu_clk_gate_bank.sv
module pmu_clk_gate_bank
    import pmu_pkg::*;
#(
    parameter int N_PERIPH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  dom_en_t             dom_req,
    input  logic [N_PERIPH-1:0] prr,
    output dom_en_t             dom_en,
    output logic [N_PERIPH-1:0] per_en
);

    // Enables move only while clk is low, like a latch-based gating cell.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dom_en <= DOM_ALL_ON;
            per_en <= '1;
        end else begin
            dom_en <= dom_req;
            per_en <= {N_PERIPH{dom_req.bus}} & ~prr;
        end
    end

endmodule

// File: rtl/pmu_reg_guard.sv
module pmu_reg_guard #(
    parameter int N_PERIPH = 4,
    parameter int DATA_W   = 8,
    parameter int IDX_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_PERIPH-1:0]        prr,
    input  logic                       bus_rd,
    input  logic                       bus_wr,
    input  logic [IDX_W-1:0]           bus_idx,
    input  logic [N_PERIPH*DATA_W-1:0] per_rdata,
    output logic [N_PERIPH-1:0]        per_wr_en,
    output logic [N_PERIPH-1:0]        per_rd_en,
    output logic [DATA_W-1:0]          bus_rdata
);

    logic [N_PERIPH-1:0] sel;

    for (genvar i = 0; i < N_PERIPH; i++) begin : g_slot
        assign sel[i]       = (bus_idx == IDX_W'(i));
        assign per_wr_en[i] = bus_wr & sel[i] & ~prr[i];
        assign per_rd_en[i] = bus_rd & sel[i] & ~prr[i];
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_PERIPH; i++) begin
            if (per_rd_en[i]) bus_rdata = bus_rdata | per_rdata[i*DATA_W +: DATA_W];
        end
    end

    assert_wr_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(per_wr_en));

    assert_blocked_rd_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (|(prr & sel))) |-> (bus_rdata == '0));

endmodule

// File: rtl/pmu_sleep_ctrl.sv
module pmu_sleep_ctrl
    import pmu_pkg::*;
#(
    parameter int N_PERIPH  = 4,
    parameter int DATA_W    = 8,
    parameter int ENTRY_CYC = 2,
    parameter int WAKE_CYC  = 6,
    localparam int IDX_W    = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sleep_en,
    input  logic                       sleep_req,
    input  logic [1:0]                 sleep_mode,
    input  logic                       irq_sync,
    input  logic                       irq_async,
    input  logic                       rtc_tick,
    input  logic                       ext_wake,
    input  logic [N_PERIPH-1:0]        prr,
    input  logic                       bus_rd,
    input  logic                       bus_wr,
    input  logic [IDX_W-1:0]           bus_idx,
    input  logic [N_PERIPH*DATA_W-1:0] per_rdata,
    output logic                       cpu_clk_en,
    output logic                       bus_clk_en,
    output logic                       osc_en,
    output logic                       rtc_clk_en,
    output logic                       bod_en,
    output logic [N_PERIPH-1:0]        per_clk_en,
    output logic [N_PERIPH-1:0]        per_wr_en,
    output logic [N_PERIPH-1:0]        per_rd_en,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic [1:0]                 state_o
);

    pmu_state_e state;
    pmu_mode_e  mode_q;
    dom_en_t    dom_req, dom_en;
    logic       wake;

    pmu_wake_qual u_wake (
        .mode      (mode_q),
        .irq_sync  (irq_sync),
        .irq_async (irq_async),
        .rtc_tick  (rtc_tick),
        .ext_wake  (ext_wake),
        .wake      (wake)
    );

    pmu_seq_fsm #(.ENTRY_CYC(ENTRY_CYC), .WAKE_CYC(WAKE_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_en  (sleep_en),
        .sleep_req (sleep_req),
        .mode_in   (sleep_mode),
        .wake      (wake),
        .state     (state),
        .mode_q    (mode_q),
        .dom_req   (dom_req)
    );

    pmu_clk_gate_bank #(.N_PERIPH(N_PERIPH)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .dom_req (dom_req),
        .prr     (prr),
        .dom_en  (dom_en),
        .per_en  (per_clk_en)
    );

    pmu_reg_guard #(.N_PERIPH(N_PERIPH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .prr       (prr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_idx   (bus_idx),
        .per_rdata (per_rdata),
        .per_wr_en (per_wr_en),
        .per_rd_en (per_rd_en),
        .bus_rdata (bus_rdata)
    );

    assign cpu_clk_en = dom_en.cpu;
    assign bus_clk_en = dom_en.bus;
    assign osc_en     = dom_en.osc;
    assign rtc_clk_en = dom_en.rtc;
    assign bod_en     = dom_en.bod;
    assign state_o    = state;

    assert_psave_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && mode_q == MD_SAVE) |-> (rtc_clk_en && !osc_en && !bod_en && !cpu_clk_en));

    assert_pdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && mode_q == MD_DOWN) |-> !(osc_en || rtc_clk_en || bod_en || bus_clk_en));

    assert_wake_bod_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE) |-> (bod_en && !cpu_clk_en));

    assert_per_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_clk_en |-> (per_clk_en == '0));

endmodule

// File: tb/pmu_sleep_ctrl_tb.sv
module pmu_sleep_ctrl_tb;

    localparam int NP = 4;
    localparam int DW = 8;

    typedef struct packed {
        logic [1:0]    st;
        logic [4:0]    dom;
        logic [NP-1:0] per;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sleep_en = 1'b0, sleep_req = 1'b0;
    logic [1:0]      sleep_mode = 2'b00;
    logic            irq_sync = 1'b0, irq_async = 1'b0, rtc_tick = 1'b0, ext_wake = 1'b0;
    logic [NP-1:0]   prr = '0;
    logic            bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0]      bus_idx = '0;
    logic [NP*DW-1:0] per_rdata = {8'hA3, 8'hA2, 8'hA1, 8'hA0};
    logic            cpu_clk_en, bus_clk_en, osc_en, rtc_clk_en, bod_en;
    logic [NP-1:0]   per_clk_en, per_wr_en, per_rd_en;
    logic [DW-1:0]   bus_rdata;
    logic [1:0]      state_o;

    int total = 0;
    int bad = 0;
    logic [1:0] cur_mode = 2'b00;
    exp_t  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    pmu_sleep_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .sleep_req(sleep_req),
        .sleep_mode(sleep_mode), .irq_sync(irq_sync), .irq_async(irq_async),
        .rtc_tick(rtc_tick), .ext_wake(ext_wake), .prr(prr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_idx(bus_idx), .per_rdata(per_rdata),
        .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en), .osc_en(osc_en),
        .rtc_clk_en(rtc_clk_en), .bod_en(bod_en), .per_clk_en(per_clk_en),
        .per_wr_en(per_wr_en), .per_rd_en(per_rd_en), .bus_rdata(bus_rdata),
        .state_o(state_o)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
        end
    endtask

    // Domain enables {cpu,bus,osc,rtc,bod} from the requirement text
    function automatic logic [4:0] dom_for(input logic [1:0] st, input logic [1:0] md);
        if (st == 2'b00) return 5'b11111;
        if (st == 2'b10) begin
            if (md == 2'b01) return 5'b00010;
            if (md == 2'b10) return 5'b00000;
        end
        return 5'b01111;
    endfunction

    // Driver: queue what the next sample must show, then move to the next drive slot
    task automatic tick(input logic [1:0] st, input string tag);
        exp_t e;
        e.st  = st;
        e.dom = dom_for(st, cur_mode);
        e.per = e.dom[3] ? ~prr : '0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk);
        #8;
    endtask

    // Monitor: sample after the falling edge, pop and compare
    initial begin
        forever begin
            @(posedge clk);
            #6;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(state_o == e.st, t, "state", 32'(state_o), 32'(e.st));
                chk({cpu_clk_en, bus_clk_en, osc_en, rtc_clk_en, bod_en} == e.dom, t, "domains",
                    32'({cpu_clk_en, bus_clk_en, osc_en, rtc_clk_en, bod_en}), 32'(e.dom));
                chk(per_clk_en == e.per, t, "per_clk_en", 32'(per_clk_en), 32'(e.per));
            end
        end
    end

    task automatic enter(input logic [1:0] md, input string tag);
        sleep_en = 1'b1; sleep_mode = md; sleep_req = 1'b1; cur_mode = md;
        tick(2'b01, "R3");
        sleep_req = 1'b0;
        tick(2'b01, "R3");
        tick(2'b10, tag);
        tick(2'b10, tag);
    endtask

    // src: 0 irq_sync, 1 irq_async, 2 rtc_tick, 3 ext_wake
    task automatic wake_up(input int src, input bit edge_chk);
        exp_t e;
        irq_sync = (src == 0); irq_async = (src == 1); rtc_tick = (src == 2); ext_wake = (src == 3);
        if (edge_chk) begin
            e.st = 2'b11; e.dom = dom_for(2'b11, cur_mode); e.per = ~prr;
            exp_q.push_back(e); tag_q.push_back("R8");
            @(posedge clk);
            #2;
            chk(bod_en == 1'b0, "R11", "bod_en before falling edge", 32'(bod_en), 32'd0);
            #6;
        end else begin
            tick(2'b11, "R8");
        end
        irq_sync = 1'b0; irq_async = 1'b0; rtc_tick = 1'b0; ext_wake = 1'b0;
        for (int k = 0; k < 5; k++) tick(2'b11, "R9");
        tick(2'b00, "R8");
        tick(2'b00, "R8");
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #8;
        chk(state_o == 2'b00, "R1", "reset state", 32'(state_o), 32'd0);
        chk({cpu_clk_en, bus_clk_en, osc_en, rtc_clk_en, bod_en} == 5'b11111, "R1", "reset domains",
            32'({cpu_clk_en, bus_clk_en, osc_en, rtc_clk_en, bod_en}), 32'h1f);
        chk(per_clk_en == '1, "R1", "reset per_clk_en", 32'(per_clk_en), 32'hf);
        rst_n = 1'b1;
        tick(2'b00, "R1");

        // R2: request without permission, then with the reserved code
        sleep_req = 1'b1; sleep_en = 1'b0;
        tick(2'b00, "R2"); tick(2'b00, "R2");
        sleep_en = 1'b1; sleep_mode = 2'b11;
        tick(2'b00, "R2"); tick(2'b00, "R2");
        sleep_req = 1'b0;

        // R4: Idle, woken by a clocked interrupt
        enter(2'b00, "R4");
        wake_up(0, 1'b0);

        // R5 and R7: Power Save ignores irq_sync, wakes on the RTC tick
        enter(2'b01, "R5");
        irq_sync = 1'b1;
        tick(2'b10, "R7");
        irq_sync = 1'b0;
        wake_up(2, 1'b0);

        // R6 and R7: Power Down ignores irq_sync and rtc_tick, wakes on the pin
        enter(2'b10, "R6");
        irq_sync = 1'b1; rtc_tick = 1'b1;
        tick(2'b10, "R7"); tick(2'b10, "R7");
        irq_sync = 1'b0; rtc_tick = 1'b0;
        wake_up(3, 1'b1);
        enter(2'b10, "R6");
        wake_up(1, 1'b0);

        // R10: wake during entry aborts it
        sleep_mode = 2'b01; sleep_req = 1'b1; cur_mode = 2'b01;
        tick(2'b01, "R10");
        sleep_req = 1'b0; ext_wake = 1'b1;
        tick(2'b00, "R10");
        ext_wake = 1'b0;
        tick(2'b00, "R10"); tick(2'b00, "R10");

        // R12: peripheral clocks follow prr and the bus domain
        prr = 4'b0101;
        tick(2'b00, "R12");
        enter(2'b00, "R12");
        wake_up(1, 1'b0);
        enter(2'b01, "R12");
        wake_up(3, 1'b0);

        // R13: register strobes and read data through the guard
        for (int i = 0; i < NP; i++) begin
            logic [DW-1:0] rexp;
            bus_idx = 2'(i); bus_wr = 1'b1; bus_rd = 1'b0;
            #1;
            chk(per_wr_en == (prr[i] ? 4'b0000 : 4'(1 << i)), "R13", "per_wr_en",
                32'(per_wr_en), prr[i] ? 32'd0 : 32'(1 << i));
            bus_wr = 1'b0; bus_rd = 1'b1;
            #1;
            rexp = prr[i] ? 8'h00 : 8'(8'hA0 + i);
            chk(per_rd_en == (prr[i] ? 4'b0000 : 4'(1 << i)), "R13", "per_rd_en",
                32'(per_rd_en), prr[i] ? 32'd0 : 32'(1 << i));
            chk(bus_rdata == rexp, "R13", "bus_rdata", 32'(bus_rdata), 32'(rexp));
            bus_rd = 1'b0;
            #1;
        end

        repeat (3) @(posedge clk);
        #8;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R8 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule